// File: doc/BRIEF.md
# Single-Cycle Integer Processor Core (32-bit, RISC Subset)

This block is a 32-bit processor core that completes one instruction in every clock cycle. On each cycle it presents the program counter on an instruction port and receives the addressed instruction word in the same cycle. It splits the word into register-register, register-immediate or long-jump fields, reads two operands from a 32-entry register file and computes a result in its ALU. It then writes the result back and selects the next program counter. Loads and stores use a word-wide data port with per-byte lane enables. Both memories are combinational-read arrays outside the core.

The core recognises a fixed set of opcode and function codes: add, subtract, set-less-than, register jump, add/compare/or with immediate, load-upper, two conditional branches, word and byte load/store, jump, and jump-and-link. Any other code retires as a no-operation. Register 0 is hardwired to zero. Jump-and-link always writes its return address to register 31. Byte operations can be removed by a parameter, in which case their opcodes behave as no-operations.

Top module: `scpu_core`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0. `imem_addr` always equals the program counter and is word aligned.
- R2: An instruction that is neither a branch nor a jump advances the program counter by 4. An unrecognised opcode (for example 63) writes no register, writes no memory, and only advances the program counter by 4.
- R3: Instruction fields are op [31:26], rs [25:21], rt [20:16], rd [15:11], imm [15:0] and target [25:0]. R-type results go to rd and I-type results go to rt. A written register reads back the new value from the next cycle on. Register 0 always reads zero, and writes to it are discarded.
- R4: Opcode 0 with funct 32 computes rs+rt, and with funct 34 computes rs-rt. Both wrap modulo 2^32 without a trap.
- R5: addi (opcode 8) adds rs to the immediate sign-extended from bit 15, wrapping modulo 2^32.
- R6: slt (opcode 0, funct 42) and slti (opcode 10, sign-extended immediate) write 1 when the first operand is less than the second in signed order, and 0 otherwise.
- R7: ori (opcode 13) ORs rs with the zero-extended immediate. lui (opcode 15) writes the immediate into bits 31:16 and zeros into bits 15:0.
- R8: beq (opcode 4) is taken when rs equals rt, and bne (opcode 5) is taken when they differ. A taken branch sets the program counter to PC+4 plus the sign-extended immediate times 4. A branch that is not taken sets it to PC+4.
- R9: j (opcode 2) and jal (opcode 3) set the program counter to {PC+4 bits 31:28, target, 2'b00}. jal also writes PC+4 into register 31.
- R10: jr (opcode 0, funct 8) sets the program counter to the value of rs.
- R11: lw (opcode 35) loads the data word at rs plus the sign-extended immediate into rt. sw (opcode 43) stores rt there, with `dmem_we` high and all four lanes enabled. Only store opcodes raise `dmem_we`.
- R12: lb (opcode 32) and sb (opcode 40) use big-endian lanes: byte address offset 0 maps to bits 31:24 and `dmem_be` bit 3, and offset 3 maps to bits 7:0 and bit 0. sb enables exactly one lane and repeats the byte on every lane of `dmem_wdata`. lb sign-extends the selected byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Byte address of the instruction to fetch (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, valid in the same cycle |
| dmem_addr | output | 32 | Byte address of a data access |
| dmem_wdata | output | 32 | Store data, byte replicated for byte stores |
| dmem_be | output | 4 | Byte-lane enables for a store, bit 3 = bits 31:24 |
| dmem_we | output | 1 | Store strobe, applied at the rising edge |
| dmem_rdata | input | 32 | Data word at the word holding `dmem_addr` |

## Verification
The arithmetic and compare instructions are swept over every pair drawn from a set of operands: zero, one, minus one, the largest positive value, the most negative value and an irregular pattern. Each pair is combined with immediates on both sides of the bit-15 sign boundary. These pairs separate wrapping from saturation, signed from unsigned comparison, and sign extension from zero extension. A second program steers control flow so that a wrong path leaves a distinct marker in memory. It covers a taken and a not-taken branch, jump, jump-and-link with a register return, an unknown opcode and a backward branch used as a halt. It also performs a byte store into an inner lane followed by byte loads of positive and negative values, which exposes lane order and sign extension. A reset applied in the middle of a run checks that the program counter returns to zero.

// File: rtl/scpu_pkg.sv
package scpu_pkg;

   localparam logic [5:0] OP_RTYPE = 6'd0;
   localparam logic [5:0] OP_J     = 6'd2;
   localparam logic [5:0] OP_JAL   = 6'd3;
   localparam logic [5:0] OP_BEQ   = 6'd4;
   localparam logic [5:0] OP_BNE   = 6'd5;
   localparam logic [5:0] OP_ADDI  = 6'd8;
   localparam logic [5:0] OP_SLTI  = 6'd10;
   localparam logic [5:0] OP_ORI   = 6'd13;
   localparam logic [5:0] OP_LUI   = 6'd15;
   localparam logic [5:0] OP_LB    = 6'd32;
   localparam logic [5:0] OP_LW    = 6'd35;
   localparam logic [5:0] OP_SB    = 6'd40;
   localparam logic [5:0] OP_SW    = 6'd43;

   localparam logic [5:0] FN_JR    = 6'd8;
   localparam logic [5:0] FN_ADD   = 6'd32;
   localparam logic [5:0] FN_SUB   = 6'd34;
   localparam logic [5:0] FN_SLT   = 6'd42;

   localparam int unsigned LINK_REG = 31;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_SLT,
      ALU_OR,
      ALU_LUI
   } alu_op_e;

   typedef enum logic [2:0] {
      FL_SEQ,
      FL_BEQ,
      FL_BNE,
      FL_JUMP,
      FL_JREG
   } flow_e;

   typedef struct packed {
      logic    reg_we;
      logic    dst_rt;
      logic    link;
      logic    use_imm;
      logic    zext;
      logic    mem_rd;
      logic    mem_wr;
      logic    mem_byte;
      alu_op_e alu;
      flow_e   flow;
   } ctrl_t;

endpackage

// File: rtl/scpu_decode.sv
module scpu_decode
   import scpu_pkg::*;
#(
   parameter bit BYTE_OPS = 1'b1
) (
   input  logic [5:0] op,
   input  logic [5:0] funct,
   output ctrl_t      ctrl
);

   always_comb begin
      ctrl      = '0;
      ctrl.alu  = ALU_ADD;
      ctrl.flow = FL_SEQ;
      case (op)
         OP_RTYPE: begin
            case (funct)
               FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_ADD; end
               FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SUB; end
               FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu = ALU_SLT; end
               FN_JR:  ctrl.flow = FL_JREG;
               default: ;
            endcase
         end
         OP_ADDI: begin
            ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
         end
         OP_SLTI: begin
            ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
            ctrl.alu = ALU_SLT;
         end
         OP_ORI: begin
            ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
            ctrl.zext = 1'b1; ctrl.alu = ALU_OR;
         end
         OP_LUI: begin
            ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
            ctrl.alu = ALU_LUI;
         end
         OP_BEQ: ctrl.flow = FL_BEQ;
         OP_BNE: ctrl.flow = FL_BNE;
         OP_J:   ctrl.flow = FL_JUMP;
         OP_JAL: begin
            ctrl.flow = FL_JUMP; ctrl.reg_we = 1'b1; ctrl.link = 1'b1;
         end
         OP_LW: begin
            ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
            ctrl.mem_rd = 1'b1;
         end
         OP_SW: begin
            ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1;
         end
         OP_LB: begin
            if (BYTE_OPS) begin
               ctrl.reg_we = 1'b1; ctrl.dst_rt = 1'b1; ctrl.use_imm = 1'b1;
               ctrl.mem_rd = 1'b1; ctrl.mem_byte = 1'b1;
            end
         end
         OP_SB: begin
            if (BYTE_OPS) begin
               ctrl.use_imm = 1'b1; ctrl.mem_wr = 1'b1; ctrl.mem_byte = 1'b1;
            end
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/scpu_alu.sv
module scpu_alu
   import scpu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  alu_op_e      op,
   output logic [W-1:0] y
);

   localparam int HALF = W / 2;

   initial begin
      if (W < 2 || (W % 2) != 0) $fatal(1, "scpu_alu: W must be even");
   end

   always_comb begin
      case (op)
         ALU_ADD: y = a + b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
         ALU_OR:  y = a | b;
         ALU_LUI: y = {b[HALF-1:0], {HALF{1'b0}}};
         default: y = a + b;
      endcase
   end

endmodule

// File: rtl/scpu_regfile.sv
module scpu_regfile #(
   parameter  int W  = 32,
   parameter  int N  = 32,
   localparam int AW = $clog2(N)
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [W-1:0]  wd,
   input  logic [AW-1:0] ra1,
   input  logic [AW-1:0] ra2,
   output logic [W-1:0]  rd1,
   output logic [W-1:0]  rd2
);

   initial begin
      if (N < 2 || (1 << AW) != N) $fatal(1, "scpu_regfile: N must be a power of two");
   end

   logic [W-1:0] regs [N];

   always_ff @(posedge clk) begin
      if (we && wa != '0) regs[wa] <= wd;
   end

   assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
   assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

   AST_RF_WRITE_READBACK: assert property (@(posedge clk) disable iff (rst)
      (we && wa != '0) |=> (ra1 != $past(wa) || rd1 == $past(wd))); // R3

endmodule

// File: rtl/scpu_core.sv
module scpu_core
   import scpu_pkg::*;
#(
   parameter int          W        = 32,
   parameter logic [31:0] RESET_PC = 32'h0,
   parameter bit          BYTE_OPS = 1'b1
) (
   input  logic        clk,
   input  logic        rst,
   output logic [31:0] imem_addr,
   input  logic [31:0] imem_rdata,
   output logic [31:0] dmem_addr,
   output logic [31:0] dmem_wdata,
   output logic [3:0]  dmem_be,
   output logic        dmem_we,
   input  logic [31:0] dmem_rdata
);

   localparam int NREG  = 32;
   localparam int RAW   = $clog2(NREG);
   localparam int BYTES = W / 8;

   initial begin
      if (W != 32) $fatal(1, "scpu_core: W must be 32");
      if (RESET_PC[1:0] != 2'b00) $fatal(1, "scpu_core: RESET_PC must be word aligned");
   end

   logic [W-1:0]   pc, pc_plus4, br_target, j_target, next_pc;
   logic [W-1:0]   instr, imm_s, imm_z, alu_b, alu_y;
   logic [W-1:0]   rs_val, rt_val, load_val;
   logic [W-1:0]   rf_wdata;
   logic [RAW-1:0] rf_waddr;
   ctrl_t          ctrl;

   assign instr     = imem_rdata;
   assign imem_addr = pc;

   scpu_decode #(.BYTE_OPS(BYTE_OPS)) u_decode (
      .op    (instr[31:26]),
      .funct (instr[5:0]),
      .ctrl  (ctrl)
   );

   assign rf_waddr = ctrl.link   ? RAW'(LINK_REG) :
                     ctrl.dst_rt ? instr[20:16] : instr[15:11];
   assign rf_wdata = ctrl.link   ? pc_plus4 :
                     ctrl.mem_rd ? load_val : alu_y;

   scpu_regfile #(.W(W), .N(NREG)) u_regs (
      .clk (clk),
      .rst (rst),
      .we  (ctrl.reg_we),
      .wa  (rf_waddr),
      .wd  (rf_wdata),
      .ra1 (instr[25:21]),
      .ra2 (instr[20:16]),
      .rd1 (rs_val),
      .rd2 (rt_val)
   );

   assign imm_s = {{(W-16){instr[15]}}, instr[15:0]};
   assign imm_z = {{(W-16){1'b0}}, instr[15:0]};
   assign alu_b = !ctrl.use_imm ? rt_val : (ctrl.zext ? imm_z : imm_s);

   scpu_alu #(.W(W)) u_alu (
      .a  (rs_val),
      .b  (alu_b),
      .op (ctrl.alu),
      .y  (alu_y)
   );

   assign dmem_addr = alu_y;
   assign dmem_we   = ctrl.mem_wr;

   generate
      if (BYTE_OPS) begin : g_byte_lanes
         logic [1:0]   lane;
         logic [W-1:0] shifted;
         assign lane    = alu_y[1:0];
         assign shifted = dmem_rdata >> {(2'd3 - lane), 3'b000};
         assign load_val   = ctrl.mem_byte ? {{(W-8){shifted[7]}}, shifted[7:0]} : dmem_rdata;
         assign dmem_be    = ctrl.mem_byte ? (4'b1000 >> lane) : 4'b1111;
         assign dmem_wdata = ctrl.mem_byte ? {BYTES{rt_val[7:0]}} : rt_val;
      end else begin : g_word_only
         assign load_val   = dmem_rdata;
         assign dmem_be    = 4'b1111;
         assign dmem_wdata = rt_val;
      end
   endgenerate

   assign pc_plus4  = pc + W'(4);
   assign br_target = pc_plus4 + {imm_s[W-3:0], 2'b00};
   assign j_target  = {pc_plus4[W-1:W-4], instr[25:0], 2'b00};

   always_comb begin
      case (ctrl.flow)
         FL_BEQ:  next_pc = (rs_val == rt_val) ? br_target : pc_plus4;
         FL_BNE:  next_pc = (rs_val != rt_val) ? br_target : pc_plus4;
         FL_JUMP: next_pc = j_target;
         FL_JREG: next_pc = rs_val;
         default: next_pc = pc_plus4;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) pc <= RESET_PC;
      else     pc <= next_pc;
   end

   AST_RESET_PC: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> imem_addr == RESET_PC); // R1

   AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
      imem_addr[1:0] == 2'b00); // R1

   AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      (ctrl.flow == FL_SEQ) |=> imem_addr == $past(imem_addr) + 32'd4); // R2

   AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OP_BEQ && rs_val == rt_val) |=>
         imem_addr == $past(imem_addr) + 32'd4 + {$past(imm_s[W-3:0]), 2'b00}); // R8

   AST_JAL_LINK: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] == OP_JAL) |->
         (ctrl.reg_we && rf_waddr == 5'd31 && rf_wdata == imem_addr + 32'd4)); // R9

   AST_STORE_ONLY: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> (instr[31:26] == OP_SW || (BYTE_OPS && instr[31:26] == OP_SB))); // R11

   AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (rst)
      dmem_we |-> ($countones(dmem_be) == 1 || dmem_be == 4'b1111)); // R12

endmodule

// File: tb/test_scpu_core.sv
`timescale 1ns/1ps
module test_scpu_core;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [31:0] imem_addr, imem_rdata;
   logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
   logic [3:0]  dmem_be;
   logic        dmem_we;

   logic [31:0] imem    [64];
   logic [31:0] dm_init [64];
   logic [31:0] dmem    [64];

   int n_checks = 0;
   int n_fails  = 0;

   always #4 clk = ~clk;

   scpu_core i_scpu_core (
      .clk        (clk),
      .rst        (rst),
      .imem_addr  (imem_addr),
      .imem_rdata (imem_rdata),
      .dmem_addr  (dmem_addr),
      .dmem_wdata (dmem_wdata),
      .dmem_be    (dmem_be),
      .dmem_we    (dmem_we),
      .dmem_rdata (dmem_rdata)
   );

   assign imem_rdata = imem[imem_addr[7:2]];
   assign dmem_rdata = dmem[dmem_addr[7:2]];

   always @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < 64; k++) dmem[k] <= dm_init[k];
      end else if (dmem_we) begin
         if (dmem_be[3]) dmem[dmem_addr[7:2]][31:24] <= dmem_wdata[31:24];
         if (dmem_be[2]) dmem[dmem_addr[7:2]][23:16] <= dmem_wdata[23:16];
         if (dmem_be[1]) dmem[dmem_addr[7:2]][15:8]  <= dmem_wdata[15:8];
         if (dmem_be[0]) dmem[dmem_addr[7:2]][7:0]   <= dmem_wdata[7:0];
      end
   end

   function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                         input logic [4:0] rd, input logic [5:0] fn);
      return {6'd0, rs, rt, rd, 5'd0, fn};
   endfunction

   function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                         input logic [4:0] rt, input logic [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   function automatic logic [31:0] enc_j(input logic [5:0] op, input logic [25:0] tgt);
      return {op, tgt};
   endfunction

   function automatic logic [31:0] sx(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic clear_mems();
      for (int k = 0; k < 64; k++) begin
         imem[k]    = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);
         dm_init[k] = 32'hDEADBEEF;
      end
   endtask

   task automatic run_prog(input int cycles, input bool_check_reset);
      @(negedge clk) rst = 1'b1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      if (bool_check_reset) check("R1 reset pc", imem_addr, 32'h0);
      rst = 1'b0;
      repeat (cycles) @(posedge clk);
      @(negedge clk);
   endtask

   logic [31:0] vals [6];
   logic [15:0] imms [4];

   initial begin
      repeat (200000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      vals = '{32'h0, 32'h1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 32'h12345678};
      imms = '{16'h0000, 16'h7FFF, 16'h8000, 16'hFFFF};

      // Arithmetic / compare sweep over operand pairs.
      for (int i = 0; i < 6; i++) begin
         for (int j = 0; j < 6; j++) begin
            logic [31:0] a, b;
            logic [15:0] im;
            a  = vals[i];
            b  = vals[j];
            im = imms[(i + j) % 4];
            clear_mems();
            dm_init[0] = a;
            dm_init[1] = b;
            imem[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
            imem[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
            imem[2]  = enc_r(5'd1, 5'd2, 5'd3, 6'd32);
            imem[3]  = enc_r(5'd1, 5'd2, 5'd4, 6'd34);
            imem[4]  = enc_r(5'd1, 5'd2, 5'd5, 6'd42);
            imem[5]  = enc_i(6'd8,  5'd1, 5'd6, im);
            imem[6]  = enc_i(6'd10, 5'd1, 5'd7, im);
            imem[7]  = enc_i(6'd13, 5'd1, 5'd8, im);
            imem[8]  = enc_i(6'd15, 5'd0, 5'd9, im);
            imem[9]  = enc_r(5'd1, 5'd2, 5'd0, 6'd32);
            for (int k = 0; k < 8; k++)
               imem[10 + k] = enc_i(6'd43, 5'd0, (k == 7) ? 5'd0 : 5'(3 + k), 16'(8 + 4 * k));
            run_prog(25, (i == 0 && j == 0));
            check("R4 R11 add", dmem[2], a + b);
            check("R4 sub",     dmem[3], a - b);
            check("R6 slt",     dmem[4], {31'd0, $signed(a) < $signed(b)});
            check("R5 addi",    dmem[5], a + sx(im));
            check("R6 slti",    dmem[6], {31'd0, $signed(a) < $signed(sx(im))});
            check("R7 ori",     dmem[7], a | {16'd0, im});
            check("R7 lui",     dmem[8], {im, 16'd0});
            check("R3 r0 write ignored", dmem[9], 32'h0);
         end
      end

      // Control flow, unknown opcode and byte lanes.
      clear_mems();
      dm_init[15] = 32'h11223344;
      for (int k = 14; k < 19; k++) imem[k] = enc_i(6'd8, 5'd0, 5'd10, 16'd9);
      imem[0]  = enc_i(6'd8, 5'd0, 5'd1, 16'd5);
      imem[1]  = enc_i(6'd8, 5'd0, 5'd2, 16'd5);
      imem[2]  = enc_i(6'd4, 5'd1, 5'd2, 16'd2);
      imem[3]  = enc_i(6'd8, 5'd0, 5'd10, 16'd1);
      imem[4]  = enc_i(6'd8, 5'd0, 5'd10, 16'd2);
      imem[5]  = enc_i(6'd5, 5'd1, 5'd2, 16'd3);
      imem[6]  = enc_i(6'd8, 5'd0, 5'd11, 16'd7);
      imem[7]  = enc_j(6'd3, 26'd12);
      imem[8]  = enc_i(6'd43, 5'd0, 5'd31, 16'd40);
      imem[9]  = enc_j(6'd2, 26'd19);
      imem[10] = enc_i(6'd8, 5'd0, 5'd10, 16'd3);
      imem[11] = enc_i(6'd8, 5'd0, 5'd10, 16'd4);
      imem[12] = enc_i(6'd13, 5'd0, 5'd12, 16'h8001);
      imem[13] = enc_r(5'd31, 5'd0, 5'd0, 6'd8);
      imem[19] = enc_i(6'd8, 5'd0, 5'd10, 16'h0055);
      imem[20] = enc_i(6'd63, 5'd0, 5'd10, 16'h1234);
      imem[21] = enc_i(6'd43, 5'd0, 5'd10, 16'd44);
      imem[22] = enc_i(6'd43, 5'd0, 5'd11, 16'd48);
      imem[23] = enc_i(6'd43, 5'd0, 5'd12, 16'd52);
      imem[24] = enc_i(6'd8, 5'd0, 5'd13, 16'hFF80);
      imem[25] = enc_i(6'd40, 5'd0, 5'd13, 16'd61);
      imem[26] = enc_i(6'd32, 5'd0, 5'd14, 16'd61);
      imem[27] = enc_i(6'd32, 5'd0, 5'd15, 16'd60);
      imem[28] = enc_i(6'd32, 5'd0, 5'd16, 16'd63);
      imem[29] = enc_i(6'd43, 5'd0, 5'd14, 16'd64);
      imem[30] = enc_i(6'd43, 5'd0, 5'd15, 16'd68);
      imem[31] = enc_i(6'd43, 5'd0, 5'd16, 16'd72);
      imem[32] = enc_i(6'd4, 5'd0, 5'd0, 16'hFFFF);
      run_prog(60, 1'b1);
      check("R9 R10 jal link stored after jr return", dmem[10], 32'd32);
      check("R2 R8 unknown opcode is nop, branches steer", dmem[11], 32'h55);
      check("R8 bne not taken falls through", dmem[12], 32'd7);
      check("R7 R9 ori at jal target", dmem[13], 32'h00008001);
      check("R12 sb inner lane", dmem[15], 32'h11803344);
      check("R12 lb negative", dmem[16], 32'hFFFFFF80);
      check("R12 lb lane 0", dmem[17], 32'h00000011);
      check("R12 lb lane 3", dmem[18], 32'h00000044);
      check("R8 backward branch halt", imem_addr, 32'd128);
      check("R2 no stray store", dmem[14], 32'hDEADBEEF);

      // Reset in the middle of a run.
      @(negedge clk) rst = 1'b1;
      @(posedge clk);
      @(negedge clk);
      check("R1 mid-run reset pc", imem_addr, 32'h0);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R2 first advance after reset", imem_addr, 32'd4);

      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule